// File: doc/BRIEF.md
# Logic-Analyzer Capture Run Controller

This block sequences one capture of a 16-channel logic analyzer. A small write-only register port sets how many samples to take in total, how many of them come before the trigger, and a 16-bit divisor that sets the sample rate. The divisor divides the fixed base clock, which is 200 MHz in the target system. Writing the run command starts a capture. Writing the halt command ends it at any point.

Once started, the block produces a sample strobe at the divided rate. It first fills the pre-trigger window. It then keeps sampling while it waits for the external `trigger_hit` input. After the trigger it takes the remaining post-trigger samples and returns to idle. Every accepted sample appears as a one-cycle `sample_valid` pulse, which a downstream memory writer consumes. A 16-bit status word reports the current phase as fixed bit codes, so software polling the word can follow the capture.

Top module: `cap_run_ctrl`

## Requirements
- R1: After reset, `status` reads 0x85E9 and `sample_valid` is low.
- R2: Register address 3 holds the divisor. A written value above 0xFFFF is stored as 0xFFFF, and a stored value of 0 behaves like 1.
- R3: While a capture runs, consecutive `sample_valid` pulses are exactly max(divisor,1) clock cycles apart.
- R4: `sample_valid` is high only in cycles where status bit 1 (writing samples) is set.
- R5: Writing 3 to address 0 starts a capture on the next clock edge. The low status nibble becomes 0x2 (pre-trigger fill) when the pre-trigger count at address 2 is nonzero. It becomes 0xA (waiting for trigger) when that count is zero, so the fill phase is skipped.
- R6: Writing 0 to address 0 returns the block to idle on the next clock edge. The low nibble becomes 0x9 if no trigger occurred in the run and 0xD if one did.
- R7: The fill phase emits exactly the pre-trigger count of pulses, and `trigger_hit` has no effect until that count is reached.
- R8: While the low nibble is 0xA, sampling continues and pulses keep arriving. A high `trigger_hit` moves the nibble to 0xE (post-trigger) on the next edge.
- R9: The post-trigger phase emits exactly max(total − pre, 0) pulses, where total is the count at address 1. The block then goes idle with status 0x85ED.
- R10: Values written to address 0 other than 0 and 3 leave the phase unchanged.
- R11: Status bits 15:4 always read 0x85E.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select: 0 run command, 1 total count, 2 pre-trigger count, 3 divisor |
| wr_data | input | 32 | Register write data |
| trigger_hit | input | 1 | Trigger condition from the external matcher |
| status | output | 16 | Phase status word |
| sample_valid | output | 1 | One-cycle pulse per accepted sample |

## Verification
A command write is taken at one rising edge, and the phase register updates at that same edge. The status is therefore checked at the falling edge that follows the write. A `trigger_hit` driven at a falling edge is seen at the next rising edge, so the 0xE nibble is expected one half-cycle later. Each `sample_valid` pulse is registered together with the phase change it belongs to. For that reason the bench samples status and pulse together at every falling edge and credits each pulse to the phase shown in the same cycle. Pulse spacing is measured in whole cycles between those same falling-edge samples.

// File: rtl/cap_pkg.sv
package cap_pkg;
  localparam int ADDR_W = 2;

  localparam logic [ADDR_W-1:0] A_MODE  = 2'd0;
  localparam logic [ADDR_W-1:0] A_TOTAL = 2'd1;
  localparam logic [ADDR_W-1:0] A_PRE   = 2'd2;
  localparam logic [ADDR_W-1:0] A_DIV   = 2'd3;

  localparam int MODE_RUN  = 3;
  localparam int MODE_HALT = 0;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_FILL = 2'd1,
    PH_ARM  = 2'd2,
    PH_POST = 2'd3
  } phase_t;
endpackage

// File: rtl/cap_cfg_regs.sv
module cap_cfg_regs
  import cap_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 32,
  parameter int DIV_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [CNT_W-1:0]  total_len,
  output logic [CNT_W-1:0]  pre_len,
  output logic [DIV_W-1:0]  div_val,
  output logic              cmd_run,
  output logic              cmd_halt
);
  localparam logic [DIV_W-1:0] DIV_MAX = {DIV_W{1'b1}};
  localparam logic [DATA_W-1:0] DIV_MAX_W = DATA_W'(DIV_MAX);

  logic mode_wr;
  assign mode_wr  = wr_en && (wr_addr == A_MODE);
  assign cmd_run  = mode_wr && (wr_data == DATA_W'(MODE_RUN));
  assign cmd_halt = mode_wr && (wr_data == DATA_W'(MODE_HALT));

  always_ff @(posedge clk) begin
    if (rst) begin
      total_len <= '0;
      pre_len   <= '0;
      div_val   <= DIV_W'(1);
    end else if (wr_en) begin
      case (wr_addr)
        A_TOTAL: total_len <= CNT_W'(wr_data);
        A_PRE:   pre_len   <= CNT_W'(wr_data);
        A_DIV:   div_val   <= (wr_data > DIV_MAX_W) ? DIV_MAX : wr_data[DIV_W-1:0];
        default: ;
      endcase
    end
  end

  // R2: an oversized divisor write lands on the saturation value
  p_div_sat_r2: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == A_DIV && wr_data > DIV_MAX_W) |=> (div_val == DIV_MAX));
endmodule

// File: rtl/cap_rate_div.sv
module cap_rate_div #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             clr,
  input  logic [DIV_W-1:0] div_val,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] lim;

  assign lim = (div_val == '0) ? '0 : div_val - DIV_W'(1);

  always_ff @(posedge clk) begin
    if (rst || clr || !run) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (cnt >= lim) begin
      cnt  <= '0;
      tick <= 1'b1;
    end else begin
      cnt  <= cnt + DIV_W'(1);
      tick <= 1'b0;
    end
  end

  // R3: no back-to-back ticks unless the divisor is one (or zero)
  p_tick_gap_r3: assert property (@(posedge clk) disable iff (rst)
    tick |=> (!tick || lim == '0));
endmodule

// File: rtl/cap_phase_fsm.sv
module cap_phase_fsm
  import cap_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd_run,
  input  logic             cmd_halt,
  input  logic             tick,
  input  logic             trigger_hit,
  input  logic [CNT_W-1:0] pre_len,
  input  logic [CNT_W-1:0] total_len,
  output phase_t           phase,
  output logic             trig_seen,
  output logic             sample_valid
);
  logic [CNT_W-1:0] pre_cnt;
  logic [CNT_W-1:0] post_cnt;
  logic [CNT_W-1:0] post_len;

  assign post_len = (total_len > pre_len) ? (total_len - pre_len) : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase        <= PH_IDLE;
      trig_seen    <= 1'b0;
      sample_valid <= 1'b0;
      pre_cnt      <= '0;
      post_cnt     <= '0;
    end else begin
      sample_valid <= 1'b0;
      if (cmd_halt) begin
        phase <= PH_IDLE;
      end else if (cmd_run) begin
        trig_seen <= 1'b0;
        pre_cnt   <= '0;
        post_cnt  <= '0;
        phase     <= (pre_len == '0) ? PH_ARM : PH_FILL;
      end else begin
        case (phase)
          PH_FILL: begin
            if (pre_cnt == pre_len) begin
              phase        <= PH_ARM;
              sample_valid <= tick;
            end else if (tick) begin
              sample_valid <= 1'b1;
              pre_cnt      <= pre_cnt + CNT_W'(1);
            end
          end
          PH_ARM: begin
            if (trigger_hit) begin
              phase     <= PH_POST;
              trig_seen <= 1'b1;
              if (tick && post_len != '0) begin
                sample_valid <= 1'b1;
                post_cnt     <= CNT_W'(1);
              end else begin
                post_cnt     <= '0;
              end
            end else begin
              sample_valid <= tick;
            end
          end
          PH_POST: begin
            if (post_cnt == post_len) begin
              phase <= PH_IDLE;
            end else if (tick) begin
              sample_valid <= 1'b1;
              post_cnt     <= post_cnt + CNT_W'(1);
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R4: a sample pulse never coincides with the idle phase
  p_valid_sampling_r4: assert property (@(posedge clk) disable iff (rst)
    sample_valid |-> (phase != PH_IDLE));

  // R6: halt always lands in idle
  p_halt_idle_r6: assert property (@(posedge clk) disable iff (rst)
    cmd_halt |=> (phase == PH_IDLE));

  // R7: unfinished fill ignores the trigger
  p_fill_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_FILL && pre_cnt != pre_len && !cmd_halt && !cmd_run) |=> (phase == PH_FILL));

  // R8: trigger while armed enters the post-trigger phase
  p_arm_to_post_r8: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_ARM && trigger_hit && !cmd_halt && !cmd_run) |=> (phase == PH_POST && trig_seen));
endmodule

// File: rtl/cap_run_ctrl.sv
module cap_run_ctrl
  import cap_pkg::*;
#(
  parameter int          DATA_W     = 32,
  parameter int          CNT_W      = 32,
  parameter int          DIV_W      = 16,
  parameter logic [11:0] STATUS_TAG = 12'h85E
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              trigger_hit,
  output logic [15:0]       status,
  output logic              sample_valid
);
  logic [CNT_W-1:0] total_len;
  logic [CNT_W-1:0] pre_len;
  logic [DIV_W-1:0] div_val;
  logic             cmd_run;
  logic             cmd_halt;
  logic             tick;
  phase_t           phase;
  logic             trig_seen;
  logic [3:0]       nib;

  cap_cfg_regs #(.DATA_W(DATA_W), .CNT_W(CNT_W), .DIV_W(DIV_W)) u_cfg (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .total_len(total_len), .pre_len(pre_len), .div_val(div_val),
    .cmd_run(cmd_run), .cmd_halt(cmd_halt)
  );

  cap_rate_div #(.DIV_W(DIV_W)) u_div (
    .clk(clk), .rst(rst), .run(phase != PH_IDLE), .clr(cmd_run),
    .div_val(div_val), .tick(tick)
  );

  cap_phase_fsm #(.CNT_W(CNT_W)) u_fsm (
    .clk(clk), .rst(rst), .cmd_run(cmd_run), .cmd_halt(cmd_halt), .tick(tick),
    .trigger_hit(trigger_hit), .pre_len(pre_len), .total_len(total_len),
    .phase(phase), .trig_seen(trig_seen), .sample_valid(sample_valid)
  );

  // bit0 idle, bit1 writing, bit2 triggered, bit3 past fill
  always_comb begin
    case (phase)
      PH_FILL: nib = 4'b0010;
      PH_ARM:  nib = 4'b1010;
      PH_POST: nib = 4'b1110;
      default: nib = {1'b1, trig_seen, 1'b0, 1'b1};
    endcase
  end

  assign status = {STATUS_TAG, nib};

  // R5: a run command leaves idle on the next edge
  p_run_leaves_idle_r5: assert property (@(posedge clk) disable iff (rst)
    (cmd_run && !cmd_halt) |=> (status[0] == 1'b0 && status[1] == 1'b1));
endmodule

// File: tb/cap_run_ctrl_tb.sv
module cap_run_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst;
  logic        wr_en;
  logic [1:0]  wr_addr;
  logic [31:0] wr_data;
  logic        trigger_hit;
  logic [15:0] status;
  logic        sample_valid;

  int n_checks = 0;
  int n_fails  = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  cap_run_ctrl u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .trigger_hit(trigger_hit), .status(status), .sample_valid(sample_valid)
  );

  // rows: divisor, pre count, total count, cycles armed before trigger
  localparam int VEC[5][4] = '{
    '{1, 3, 8, 2},
    '{4, 0, 5, 9},
    '{3, 5, 5, 3},
    '{0, 2, 1, 6},
    '{2, 6, 3, 0}
  };

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic write_reg(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic run_capture(input int dv, input int pre, input int tot,
                             input int twait, input bit early);
    int gap, exp_post, c_fill, c_arm, c_post, last, gap_err, bad_valid, waits, cyc;
    bit done, trig_ignored;
    gap      = (dv == 0) ? 1 : dv;
    exp_post = (tot > pre) ? tot - pre : 0;
    c_fill = 0; c_arm = 0; c_post = 0; last = -1; gap_err = 0; bad_valid = 0;
    waits = 0; cyc = 0; done = 0; trig_ignored = 1;
    write_reg(2'd3, dv);
    write_reg(2'd2, pre);
    write_reg(2'd1, tot);
    if (early) trigger_hit = 1'b1;
    write_reg(2'd0, 32'd3);
    // R5: first phase after the run command
    check(status[3:0] == ((pre == 0) ? 4'hA : 4'h2), "R5", status[3:0], (pre == 0) ? 4'hA : 4'h2);
    while (!done && cyc < 5000) begin
      if (sample_valid) begin
        if (!status[1]) bad_valid++;
        if (status[3:0] == 4'h2) c_fill++;
        if (status[3:0] == 4'hA) c_arm++;
        if (status[3:0] == 4'hE) c_post++;
        if (last >= 0 && cyc - last != gap) gap_err++;
        last = cyc;
      end
      if (early && status[3:0] == 4'hE && c_fill != pre) trig_ignored = 0;
      if (status[3:0] == 4'hA) begin
        if (waits >= twait) trigger_hit = 1'b1;
        waits++;
      end
      if (status[3:0] == 4'hE) trigger_hit = 1'b0;
      if (status[3:0] == 4'hD) done = 1;
      else begin
        @(negedge clk);
        cyc++;
      end
    end
    trigger_hit = 1'b0;
    check(c_fill == pre, "R7 fill pulses", c_fill, pre);
    check(c_post == exp_post, "R9 post pulses", c_post, exp_post);
    check(status == 16'h85ED, "R9 end status", status, 16'h85ED);
    check(gap_err == 0, "R3 pulse spacing", gap_err, 0);
    check(bad_valid == 0, "R4 pulse outside writing", bad_valid, 0);
    if (early) check(trig_ignored, "R7 early trigger ignored", c_fill, pre);
    if (twait >= 2 * gap) check(c_arm > 0, "R8 sampling while armed", c_arm, 1);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog actual=0x0 expected=0x1");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    int t0, t1, seen;
    rst = 1'b1; wr_en = 1'b0; wr_addr = '0; wr_data = '0; trigger_hit = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state, R11 constant upper bits
    check(status == 16'h85E9, "R1 reset status", status, 16'h85E9);
    check(sample_valid == 1'b0, "R1 reset valid", sample_valid, 0);

    // R10: stray mode value while idle
    write_reg(2'd0, 32'd1);
    check(status == 16'h85E9, "R10 idle stray mode", status, 16'h85E9);

    for (int i = 0; i < 5; i++)
      run_capture(VEC[i][0], VEC[i][1], VEC[i][2], VEC[i][3], 1'b0);

    // R7: trigger held high through the whole fill
    run_capture(2, 4, 6, 0, 1'b1);

    // R6: halt during fill, no trigger
    write_reg(2'd3, 32'd2); write_reg(2'd2, 32'd50); write_reg(2'd1, 32'd60);
    write_reg(2'd0, 32'd3);
    repeat (4) @(negedge clk);
    write_reg(2'd0, 32'd0);
    check(status == 16'h85E9, "R6 halt untriggered", status, 16'h85E9);
    check(status[15:4] == 12'h85E, "R11 upper bits", status[15:4], 12'h85E);

    // R10: stray mode while armed, then R6 halt after trigger
    write_reg(2'd2, 32'd0); write_reg(2'd1, 32'd200);
    write_reg(2'd0, 32'd3);
    write_reg(2'd0, 32'd2);
    check(status[3:0] == 4'hA, "R10 armed stray mode", status[3:0], 4'hA);
    trigger_hit = 1'b1;
    @(negedge clk);
    trigger_hit = 1'b0;
    check(status[3:0] == 4'hE, "R8 trigger to post", status[3:0], 4'hE);
    write_reg(2'd0, 32'd0);
    check(status == 16'h85ED, "R6 halt triggered", status, 16'h85ED);

    // R2: saturated divisor gives 0xFFFF-cycle spacing
    write_reg(2'd3, 32'h0001_2345); write_reg(2'd2, 32'd3); write_reg(2'd1, 32'd3);
    write_reg(2'd0, 32'd3);
    t0 = 0; t1 = 0; seen = 0;
    for (int c = 0; c < 140000 && seen < 2; c++) begin
      if (sample_valid) begin
        if (seen == 0) t0 = c; else t1 = c;
        seen++;
      end
      @(negedge clk);
    end
    check(seen == 2 && (t1 - t0) == 65535, "R2 divisor saturation", t1 - t0, 65535);
    write_reg(2'd0, 32'd0);
    check(status == 16'h85E9, "R6 halt after long fill", status, 16'h85E9);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule